// File: doc/BRIEF.md
# Iterative Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `OP_W` bits (32 by default) and produces a product of twice that width. It computes one multiplier bit per clock. A single product register does the work of two registers. At start its lower half takes the multiplier and its upper half is cleared. Each step looks at the lowest product bit. When that bit is set, the step adds the stored multiplicand into the upper half. The whole register then moves right by one place. As the multiplier bits are used up, the finished low-order product bits move into the space they leave, so one adder of operand width is enough.

A caller pulses `start` with both operands present while the block is idle. `busy` stays high for the operand-width steps that follow. A one-cycle `done` pulse then marks that the two product halves are ready. They stay readable until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `busy` and `done` are 0 and `prod_hi` and `prod_lo` are 0.
- R2: A `start` seen at an edge while idle loads the operands. After that edge `busy` is 1, `prod_lo` equals the `op_b` sampled there and `prod_hi` is 0.
- R3: In each step, when product bit 0 is 1 the multiplicand is added to the upper half, otherwise nothing is added. The whole product then moves right by one bit.
- R4: Exactly `OP_W` steps follow the load edge. `done` is 1 in the cycle after the `OP_W`-th step edge, which is `OP_W`+1 edges after the start edge, and `busy` falls at that same edge.
- R5: When `done` is 1, `prod_hi` is the upper half and `prod_lo` the lower half of the unsigned product `op_a * op_b` sampled at the start edge.
- R6: A `start` seen while `busy` is 1 is ignored. The result and the timing of `done` stay those of the operation in progress.
- R7: While idle and with no `start`, `prod_hi` and `prod_lo` keep their values, whatever the operand inputs do.
- R8: `done` is a single-cycle pulse.
- R9: The carry out of each addition goes into the top product bit, so full-scale operands (all ones times all ones) give the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiply when idle |
| op_a | input | OP_W | Multiplicand |
| op_b | input | OP_W | Multiplier |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse: result ready |
| prod_hi | output | OP_W | Upper half of the product |
| prod_lo | output | OP_W | Lower half of the product |

## Verification
The bench builds two copies of the block. One uses the default `OP_W` of 32, where it checks tabled full-scale and edge operands, a pseudo-random sweep, an ignored mid-run start, result hold and reset during a run. The other uses `OP_W` of 4, which makes an exhaustive sweep of all 256 operand pairs practical, so every carry and shift path of the step logic is covered at a small width with a 5-edge operation.

// File: rtl/shm_pkg.sv
package shm_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Counter width able to hold values 0 .. width-1 with one bit of margin.
    function automatic int unsigned step_cnt_width(input int unsigned width);
        return $clog2(width) + 1;
    endfunction

endpackage

// File: rtl/shm_sequencer.sv
module shm_sequencer
    import shm_pkg::*;
#(
    parameter int unsigned OP_W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = step_cnt_width(OP_W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(OP_W - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    assign busy = (state_q == SEQ_RUN);
    assign step = busy;
    assign load = start && !busy;
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (cnt_q == LAST_STEP) begin
                        state_q <= SEQ_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                   // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                   // R4
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q <= LAST_STEP));                    // R4

endmodule

// File: rtl/shm_datapath.sv
module shm_datapath #(
    parameter int unsigned OP_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [OP_W-1:0]   mcand_in,
    input  logic [OP_W-1:0]   mplier_in,
    output logic [2*OP_W-1:0] product
);
    localparam int unsigned PW = 2 * OP_W;

    logic [OP_W-1:0] mcand_q;
    logic [PW-1:0]   prod_q;
    logic [OP_W-1:0] addend;
    logic [OP_W:0]   upper_sum;

    // Conditional add: the lowest product bit is the current multiplier bit.
    assign addend    = prod_q[0] ? mcand_q : '0;
    assign upper_sum = {1'b0, prod_q[PW-1:OP_W]} + {1'b0, addend};
    assign product   = prod_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q  <= '0;
            mcand_q <= '0;
        end else if (load) begin
            prod_q  <= {{OP_W{1'b0}}, mplier_in};
            mcand_q <= mcand_in;
        end else if (step) begin
            // Sum carry lands in the top bit; multiplier bits fall off the bottom.
            prod_q <= {upper_sum, prod_q[OP_W-1:1]};
        end
    end

    AST_MCAND_FROZEN: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(mcand_q));                        // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(prod_q));             // R7

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int unsigned OP_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    output logic            busy,
    output logic            done,
    output logic [OP_W-1:0] prod_hi,
    output logic [OP_W-1:0] prod_lo
);
    localparam int unsigned PW = 2 * OP_W;

    logic          load;
    logic          step;
    logic [PW-1:0] product;

    shm_sequencer #(.OP_W(OP_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    shm_datapath #(.OP_W(OP_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .mcand_in  (op_a),
        .mplier_in (op_b),
        .product   (product)
    );

    assign prod_hi = product[PW-1:OP_W];
    assign prod_lo = product[OP_W-1:0];

    AST_LOAD_INIT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && prod_hi == '0 && prod_lo == $past(op_b))); // R2
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!busy && !done && prod_hi == '0 && prod_lo == '0));           // R1

endmodule

// File: tb/tb_shift_add_mul.sv
module tb_shift_add_mul;

    localparam int unsigned W  = 32;
    localparam int unsigned WS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;   // 200 MHz

    logic          start = 1'b0;
    logic [W-1:0]  op_a = '0, op_b = '0;
    logic          busy, done;
    logic [W-1:0]  prod_hi, prod_lo;

    logic          s_start = 1'b0;
    logic [WS-1:0] s_a = '0, s_b = '0;
    logic          s_busy, s_done;
    logic [WS-1:0] s_hi, s_lo;

    shift_add_mul #(.OP_W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo));

    shift_add_mul #(.OP_W(WS)) dut_n (
        .clk(clk), .rst(rst), .start(s_start), .op_a(s_a), .op_b(s_b),
        .busy(s_busy), .done(s_done), .prod_hi(s_hi), .prod_lo(s_lo));

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // {multiplicand, multiplier, expected product}
    localparam int NV = 10;
    localparam logic [127:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 64'h0000_0000_0000_0000},
        {32'h0000_0001, 32'h0000_0001, 64'h0000_0000_0000_0001},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFE_0000_0001},
        {32'hFFFF_FFFF, 32'h0000_0001, 64'h0000_0000_FFFF_FFFF},
        {32'h8000_0000, 32'h0000_0002, 64'h0000_0001_0000_0000},
        {32'h1234_5678, 32'h0000_0000, 64'h0000_0000_0000_0000},
        {32'h0001_0000, 32'h0001_0000, 64'h0000_0001_0000_0000},
        {32'h0000_0003, 32'h0000_0007, 64'h0000_0000_0000_0015},
        {32'hFFFF_FFFF, 32'h0000_0002, 64'h0000_0001_FFFF_FFFE},
        {32'h8000_0000, 32'h8000_0000, 64'h4000_0000_0000_0000}
    };

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Full-width run: start at an edge, check load, step timing, done and result.
    task automatic run_wide(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [63:0] exp, input string req);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);                 // after load edge
        start = 1'b0;
        check("R2 busy after load", {63'd0, busy}, 64'd1);
        check("R2 load halves", {prod_hi, prod_lo}, {32'd0, b});
        for (int k = 1; k < W; k++) begin
            @(negedge clk);
            if (done !== 1'b0) check("R4 early done", {63'd0, done}, 64'd0);
        end
        @(negedge clk);                 // after step W
        check("R4 done on time", {62'd0, done, busy}, 64'd2);
        check(req, {prod_hi, prod_lo}, exp);
        @(negedge clk);
        check("R8 done single cycle", {63'd0, done}, 64'd0);
    endtask

    task automatic run_small(input logic [WS-1:0] a, input logic [WS-1:0] b);
        logic [7:0] exp;
        exp = 8'(a) * 8'(b);
        @(negedge clk);
        s_a = a; s_b = b; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        for (int k = 1; k < WS; k++) @(negedge clk);
        @(negedge clk);
        check("R5 R3 narrow exhaustive", {55'd0, s_done, s_hi, s_lo}, {55'd0, 1'b1, exp});
    endtask

    initial begin
        logic [31:0] seed;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset state", {62'd0, busy, done}, 64'd0);
        check("R1 reset product", {prod_hi, prod_lo}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {prod_hi, prod_lo}, 64'd0);

        for (int i = 0; i < NV; i++)
            run_wide(VEC[i][127:96], VEC[i][95:64], VEC[i][63:0], "R5 R9 vector");

        // R5: pseudo-random operands, expected from a bench-side multiply
        seed = 32'h1ACE_B00C;
        for (int i = 0; i < 20; i++) begin
            logic [W-1:0] a, b;
            seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
            run_wide(a, b, 64'(a) * 64'(b), "R5 random");
        end

        // R7: result holds while idle and operands change
        held = {prod_hi, prod_lo};
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            op_a = op_a ^ 32'hA5A5_5A5A; op_b = op_b + 32'd77;
        end
        check("R7 hold while idle", {prod_hi, prod_lo}, held);

        // R6: start during busy is ignored
        @(negedge clk);
        op_a = 32'd5; op_b = 32'd6; start = 1'b1;
        @(negedge clk);                 // after load edge
        start = 1'b0;
        for (int k = 1; k < 10; k++) @(negedge clk);
        op_a = 32'd7; op_b = 32'd9; start = 1'b1;
        @(negedge clk);                 // after step edge 10
        start = 1'b0;
        check("R6 still busy", {62'd0, busy, done}, 64'd2);
        for (int k = 11; k < W; k++) @(negedge clk);
        @(negedge clk);
        check("R6 done timing unchanged", {62'd0, done, busy}, 64'd2);
        check("R6 result of first operands", {prod_hi, prod_lo}, 64'd30);

        // R1: reset in the middle of a run
        @(negedge clk);
        op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", {busy, done, prod_hi, prod_lo}, 66'd0);
        rst = 1'b0;

        // R3 R5: exhaustive narrow instance
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                run_small(WS'(a), WS'(b));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule